// File: doc/BRIEF.md
# Auto-Baud Single-Wire Serial Port

This block is a half-duplex asynchronous serial port on one shared data pin. A free-running clock of roughly 1 MHz times everything. The port does not know the host's bit rate when it starts. It learns it from a fixed setup byte of value 01h. In that byte, the seven data bits that follow bit 0 form one long low run, and the port divides the length of that run by seven to get the bit period. Once the period is known, the port takes in 8N1 frames (start bit, eight data bits least significant first, stop bit, no parity). Each good byte appears on a one-cycle strobe.

A received byte of FFh puts the port back into its unlearned power-up state, so the host can change rate. A new setup byte must follow before any more bytes are delivered. When the host asks for a reply, the port first leaves the pin released for one byte time, with a weak pull-up holding it high. It then drives a start bit, the reply byte and a stop bit, and releases the pin again. All pin activity is ignored unless communication is enabled, which means the lock code input is 00h or the unlock input is high.

Back-pressure rules:
- Received bytes have no back-pressure: `rx_valid` is a single-cycle pulse, and the consumer must take `rx_data` in that cycle.
- The reply path is valid/ready. A byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high.
- `tx_data` must stay stable while `tx_valid` waits.
- `tx_ready` is high only while the bit period is known, communication is enabled, and neither the receiver nor the transmitter is busy.

Top module: `autobaud_port`

## Requirements
- R1: A frame of a low start bit, eight data bits with bit 0 first, and a high stop bit yields exactly one single-cycle `rx_valid` pulse with `rx_data` equal to the byte.
- R2: A setup byte 01h is accepted at bit periods of 26 to 208 clocks (38,400 down to 4800 bit/s at 1 MHz). The learned period is the low run of bits 1..7 divided by seven, and `tx_ready` rises once it is learned.
- R3: Until a setup byte has been accepted, no `rx_valid` pulse occurs and `tx_ready` stays low, even when other bytes arrive. A candidate whose start bit is not within half a period of the measured period, or whose period is below 8 clocks, is rejected.
- R4: A received FFh gives no strobe and returns the port to the unlearned state (`tx_ready` low). Later bytes are not delivered until a new 01h arrives.
- R5: With the lock code not 00h and `unlock` low, the pin is ignored, `line_oe` stays low and `tx_ready` stays low. Either lock code 00h or `unlock` high enables the port.
- R6: A low pulse that has returned high by the middle of the start bit is discarded with no strobe, and the next frame is received normally.
- R7: A frame whose stop bit samples low is dropped without a strobe. The port waits for the line to go high before it looks for the next start bit.
- R8: After a reply is accepted, `line_oe` stays low for exactly ten bit periods. It is then high for ten bit periods, with `line_out` giving a low start bit, the data with bit 0 first, and a high stop bit. After that `line_oe` falls.
- R9: `tx_ready` falls after a transfer and stays low while the reply is in progress. The port's own driven bits are not received as bytes.
- R10: After reset, `line_oe`, `rx_valid` and `tx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, about 1 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_code | input | 8 | Stored lock code; 00h enables communication |
| unlock | input | 1 | High forces communication enabled |
| line_in | input | 1 | Level seen on the shared pin |
| line_out | output | 1 | Level driven on the pin when `line_oe` is high |
| line_oe | output | 1 | Pin drive enable; low releases the pin |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Reply byte |
| tx_valid | input | 1 | Reply byte offered |
| tx_ready | output | 1 | Reply byte can be accepted |

## Verification
Bytes are received at the fast and slow ends of the rate range and at an odd period of 33 clocks. Each new rate goes through the relearn-then-setup sequence, which separates a correct divide-by-seven from an off-by-one sampling point. The byte values 00h, FEh, 5Ah, 3Ch, 81h, 7Eh and C3h expose bit-order and edge-of-frame errors. Alternating patterns sent before setup, and after a relearn, test the rejection of false setup candidates. A short glitch, a frame with its stop bit held low, a disabled pin and a reply with its byte-time silence are each checked at the pins.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
  typedef enum logic [3:0] {
    RX_HUNT, RX_L_START, RX_L_HIGH, RX_L_RUN,
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HI
  } rx_state_e;

  typedef enum logic [1:0] {TX_IDLE, TX_GAP, TX_SEND} tx_state_e;

  localparam int FRAME_BITS = 10;
  localparam logic [7:0] SETUP_BYTE = 8'h01;
  localparam logic [7:0] RELEARN_BYTE = 8'hFF;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  assign q = sr[STAGES-1];
endmodule

// File: rtl/ab_rx.sv
module ab_rx
  import autobaud_pkg::*;
#(
  parameter int PER_W   = 10,
  parameter int MIN_PER = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  output logic [PER_W-1:0] period,
  output logic             learned,
  output logic             idle,
  output logic [7:0]       rx_data,
  output logic             rx_valid
);
  localparam int LW = PER_W + 1;
  localparam int HW = PER_W + 2;

  rx_state_e        st;
  logic             prev;
  logic [PER_W-1:0] cnt;
  logic [LW-1:0]    len;
  logic [HW-1:0]    hi_len;
  logic [2:0]       sub7;
  logic [PER_W-1:0] acc;
  logic [7:0]       shreg;
  logic [2:0]       bitn;

  wire fall = prev && !line;
  wire [LW-1:0] acc_x  = {1'b0, acc};
  wire [LW-1:0] half_x = {2'b0, acc[PER_W-1:1]};
  wire [LW-1:0] lo_lim = acc_x - half_x;
  wire [LW-1:0] hi_lim = acc_x + half_x;
  wire cand_ok = (acc >= PER_W'(MIN_PER)) && (len >= lo_lim) && (len <= hi_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_HUNT; prev <= 1'b1; learned <= 1'b0; period <= '0;
      cnt <= '0; len <= '0; hi_len <= '0; sub7 <= '0; acc <= '0;
      shreg <= '0; bitn <= '0; rx_data <= '0; rx_valid <= 1'b0;
    end else begin
      prev     <= line;
      rx_valid <= 1'b0;
      case (st)
        RX_HUNT: if (fall) begin
          st  <= RX_L_START;
          len <= LW'(1);
        end
        RX_L_START: begin
          if (line) begin
            st     <= RX_L_HIGH;
            hi_len <= HW'(1);
          end else if (len == '1) st <= RX_HUNT;
          else len <= len + 1'b1;
        end
        RX_L_HIGH: begin
          if (!line) begin
            st   <= RX_L_RUN;
            sub7 <= 3'd1;
            acc  <= '0;
          end else if (hi_len > {len, 1'b0}) st <= RX_HUNT;
          else hi_len <= hi_len + 1'b1;
        end
        RX_L_RUN: begin
          if (line) begin
            if (cand_ok) begin
              period  <= acc;
              learned <= 1'b1;
              st      <= RX_IDLE;
            end else st <= RX_HUNT;
          end else if (acc == '1) st <= RX_HUNT;
          else if (sub7 == 3'd6) begin
            sub7 <= '0;
            acc  <= acc + 1'b1;
          end else sub7 <= sub7 + 1'b1;
        end
        RX_IDLE: if (fall) begin
          st  <= RX_START;
          cnt <= (period >> 1) - 1'b1;
        end
        RX_START: begin
          if (cnt == '0) begin
            if (!line) begin
              st   <= RX_DATA;
              cnt  <= period - 1'b1;
              bitn <= '0;
            end else st <= RX_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        RX_DATA: begin
          if (cnt == '0) begin
            shreg <= {line, shreg[7:1]};
            cnt   <= period - 1'b1;
            if (bitn == 3'd7) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        RX_STOP: begin
          if (cnt == '0) begin
            if (!line) st <= RX_WAIT_HI;
            else if (shreg == RELEARN_BYTE) begin
              learned <= 1'b0;
              st      <= RX_HUNT;
            end else begin
              rx_valid <= 1'b1;
              rx_data  <= shreg;
              st       <= RX_IDLE;
            end
          end else cnt <= cnt - 1'b1;
        end
        RX_WAIT_HI: if (line) st <= RX_IDLE;
        default: st <= RX_HUNT;
      endcase
    end
  end

  assign idle = (st == RX_IDLE);

  // R1
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R3
  rx_learned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> learned);
  // R2
  period_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    learned |-> (period >= PER_W'(MIN_PER)));
endmodule

// File: rtl/ab_tx.sv
module ab_tx
  import autobaud_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  input  logic             start,
  input  logic [7:0]       data,
  output logic             idle,
  output logic             line_out,
  output logic             line_oe
);
  localparam int BW = $clog2(FRAME_BITS);

  tx_state_e               st;
  logic [PER_W-1:0]        cnt;
  logic [BW-1:0]           bitn;
  logic [FRAME_BITS-1:0]   shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; cnt <= '0; bitn <= '0; shreg <= '1;
    end else if (!en) begin
      st <= TX_IDLE;
    end else begin
      case (st)
        TX_IDLE: if (start) begin
          shreg <= {1'b1, data, 1'b0};
          cnt   <= period - 1'b1;
          bitn  <= '0;
          st    <= TX_GAP;
        end
        TX_GAP, TX_SEND: begin
          if (cnt == '0) begin
            cnt <= period - 1'b1;
            if (st == TX_SEND) shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            if (bitn == BW'(FRAME_BITS - 1)) begin
              bitn <= '0;
              st   <= (st == TX_GAP) ? TX_SEND : TX_IDLE;
            end else bitn <= bitn + 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign idle     = (st == TX_IDLE);
  assign line_oe  = (st == TX_SEND);
  assign line_out = shreg[0];

  // R8
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_out);
endmodule

// File: rtl/autobaud_port.sv
module autobaud_port
  import autobaud_pkg::*;
#(
  parameter int PER_W       = 10,
  parameter int MIN_PER     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] lock_code,
  input  logic       unlock,
  input  logic       line_in,
  output logic       line_out,
  output logic       line_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready
);
  logic             comm_en;
  logic             line_s;
  logic             line_g;
  logic [PER_W-1:0] period;
  logic             learned;
  logic             rx_idle;
  logic             tx_idle;

  assign comm_en = unlock || (lock_code == 8'h00);

  ab_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  assign line_g = (comm_en && tx_idle) ? line_s : 1'b1;

  ab_rx #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_rx (
    .clk(clk), .rst_n(rst_n), .line(line_g), .period(period),
    .learned(learned), .idle(rx_idle), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign tx_ready = comm_en && learned && rx_idle && tx_idle;

  ab_tx #(.PER_W(PER_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(comm_en), .period(period),
    .start(tx_valid && tx_ready), .data(tx_data), .idle(tx_idle),
    .line_out(line_out), .line_oe(line_oe)
  );

  // R5
  oe_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> comm_en);
  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R9
  no_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !rx_valid);
  // R4
  no_relearn_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_data != 8'hFF));
endmodule

// File: tb/autobaud_port_tb.sv
module autobaud_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lock_code = 8'hFF;
  logic       unlock = 1'b0;
  logic       host_line = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       line_out, line_oe, rx_valid, tx_ready;
  logic [7:0] rx_data;
  wire        pin = line_oe ? line_out : host_line;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  logic [7:0] last_rx = 8'h00;

  always #10 clk = ~clk;

  autobaud_port u_dut (
    .clk(clk), .rst_n(rst_n), .lock_code(lock_code), .unlock(unlock),
    .line_in(pin), .line_out(line_out), .line_oe(line_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  always @(negedge clk) if (rx_valid) begin
    strobes++;
    last_rx = rx_data;
  end

  // period in bits 15:8, byte in 7:0
  localparam logic [15:0] VEC [7] = '{
    {8'd26, 8'h5A}, {8'd26, 8'h00}, {8'd26, 8'hFE},
    {8'd104, 8'h3C}, {8'd104, 8'h81}, {8'd208, 8'h7E}, {8'd33, 8'hC3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int p, input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      host_line = f[i];
      repeat (p) @(negedge clk);
    end
    host_line = 1'b1;
    repeat (3 * p) @(negedge clk);
  endtask

  task automatic send_byte(input int p, input logic [7:0] b);
    send_frame(p, b, 1'b1);
  endtask

  task automatic expect_none(input int p, input logic [7:0] b, input string req);
    int s0;
    s0 = strobes;
    send_byte(p, b);
    check(strobes == s0, req, strobes - s0, 0);
  endtask

  task automatic expect_byte(input int p, input logic [7:0] b, input string req);
    int s0;
    s0 = strobes;
    send_byte(p, b);
    check(strobes == s0 + 1 && last_rx == b, req, last_rx, b);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cur;
    int p;
    int k;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!line_oe && !rx_valid && !tx_ready, "R10", {line_oe, rx_valid, tx_ready}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!line_oe && !tx_ready, "R10", {line_oe, tx_ready}, 0);

    // R5 disabled: setup and byte are ignored
    send_byte(52, 8'h01);
    expect_none(52, 8'h5A, "R5");
    check(!tx_ready && !line_oe, "R5", {tx_ready, line_oe}, 0);

    // R3 enable by unlock, non-setup byte before setup
    unlock = 1'b1;
    repeat (5) @(negedge clk);
    expect_none(52, 8'h55, "R3");
    check(!tx_ready, "R3", tx_ready, 0);

    // R1 R2 vector walk
    cur = 0;
    for (int i = 0; i < 7; i++) begin
      p = int'(VEC[i][15:8]);
      if (p != cur) begin
        if (cur != 0) begin
          send_byte(cur, 8'hFF);
          check(!tx_ready, "R4", tx_ready, 0);
        end
        send_byte(p, 8'h01);
        check(tx_ready, "R2", tx_ready, 1);
        cur = p;
      end
      expect_byte(p, VEC[i][7:0], "R1");
    end

    // R4 relearn then byte without setup
    send_byte(cur, 8'hFF);
    check(!tx_ready, "R4", tx_ready, 0);
    expect_none(52, 8'hA5, "R4");
    send_byte(52, 8'h01);
    check(tx_ready, "R2", tx_ready, 1);

    // R6 glitch
    begin
      int s0;
      s0 = strobes;
      host_line = 1'b0;
      repeat (5) @(negedge clk);
      host_line = 1'b1;
      repeat (104) @(negedge clk);
      check(strobes == s0, "R6", strobes - s0, 0);
    end
    expect_byte(52, 8'hA5, "R6");

    // R7 missing stop bit
    begin
      int s0;
      s0 = strobes;
      send_frame(52, 8'h3C, 1'b0);
      check(strobes == s0, "R7", strobes - s0, 0);
    end
    expect_byte(52, 8'h81, "R7");

    // R8 R9 reply
    begin
      int s0;
      s0 = strobes;
      tx_data = 8'h96;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      check(!tx_ready, "R9", tx_ready, 0);
      k = 0;
      while (!line_oe && k < 5000) begin
        @(negedge clk);
        k++;
      end
      check(k >= 519 && k <= 521, "R8", k, 520);
      repeat (26) @(negedge clk);
      check(pin == 1'b0, "R8", pin, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (52) @(negedge clk);
        d[i] = pin;
      end
      check(d == 8'h96, "R8", d, 8'h96);
      repeat (52) @(negedge clk);
      check(line_oe && pin, "R8", {line_oe, pin}, 3);
      check(!tx_ready, "R9", tx_ready, 0);
      repeat (52) @(negedge clk);
      check(!line_oe, "R8", line_oe, 0);
      check(strobes == s0, "R9", strobes - s0, 0);
      repeat (10) @(negedge clk);
      check(tx_ready, "R9", tx_ready, 1);
    end

    // R5 disable again, then enable via lock code 00h
    unlock = 1'b0;
    repeat (5) @(negedge clk);
    check(!tx_ready, "R5", tx_ready, 0);
    expect_none(52, 8'h42, "R5");
    lock_code = 8'h00;
    repeat (5) @(negedge clk);
    expect_byte(52, 8'h24, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule